// File: doc/BRIEF.md
# Timer Status Flags with Fast-Clear

This block keeps the status flags of a general-purpose timer and decides when they clear. It holds one flag per capture/compare channel, an overflow flag for the free-running count, and two flags for the pulse accumulator: overflow and input edge. A small register bus gives software access to a two-bit control register, the flag registers, the interrupt mask registers and the two bytes of the running count.

Flags are set by event inputs and can be cleared in one of two ways. With fast-clear off, software clears a flag by writing a 1 to its bit. With fast-clear on, those writes are ignored. Instead, a flag clears when the data register it belongs to is accessed. A capture read or a compare write clears the flag of that channel. Any access to a byte of the count clears the overflow flag. Any access to the pulse-accumulator count clears both pulse-accumulator flags. The run bit gates the counter, and the registers remain accessible while the counter is stopped. Each flag, ANDed with its mask bit, drives an interrupt output.

Top module: `tmrflg_top`

## Requirements
- R1: The control register (address 0) resets to 0. It holds the fast-clear bit at bit 0 and the run bit at bit 1. Bits 7..2 always read 0, and writes to those bits are ignored.
- R2: The count increments by one on each clock edge where run=1 and tick=1. While run=0 it holds its value, and every register can still be read and written. The count reads as its low byte at address 6 and its upper bits, zero-extended, at address 5.
- R3: When the count steps from all-ones to 0, the overflow flag (bit 0 of address 2) is set.
- R4: With fast-clear=0, writing 1 to a bit of the channel flag register (address 1) or of the misc flag register (address 2) clears that flag. Writing 0 to a flag bit has no effect.
- R5: With fast-clear=1, writes to the flag registers leave the flags unchanged.
- R6: With fast-clear=1, a pulse on cap_rd_stb[i] or cmp_wr_stb[i] clears channel flag i and no other flag. With fast-clear=0 these strobes clear nothing.
- R7: With fast-clear=1, a bus read or write of address 5 or 6 clears the overflow flag. With fast-clear=0 such an access leaves the flag unchanged.
- R8: With fast-clear=1, a pulse on pa_acc_stb clears both the pulse-accumulator overflow flag (address 2 bit 1) and the edge flag (address 2 bit 2). With fast-clear=0 the strobe clears nothing.
- R9: When a set event and a clear condition hit the same flag in the same cycle, the flag ends up set.
- R10: irq_ch equals the channel flags ANDed with the channel mask (address 3). irq_misc equals the misc flags ANDed with the misc mask (address 4, bits 2..0).
- R11: A pulse on ch_evt[i], pa_ovf_evt or pa_edge_evt sets the matching flag at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access strobe for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from the address |
| tick | input | 1 | Prescaled count tick |
| ch_evt | input | NUM_CH | Per-channel capture/compare event |
| pa_ovf_evt | input | 1 | Pulse-accumulator overflow event |
| pa_edge_evt | input | 1 | Pulse-accumulator input-edge event |
| cap_rd_stb | input | NUM_CH | Capture register read strobe, per channel |
| cmp_wr_stb | input | NUM_CH | Compare register write strobe, per channel |
| pa_acc_stb | input | 1 | Pulse-accumulator count access strobe |
| count | output | CNT_W | Free-running count value |
| irq_ch | output | NUM_CH | Masked channel interrupt requests |
| irq_misc | output | 3 | Masked overflow, accumulator-overflow and edge interrupt requests |

## Verification
The bench builds the block with eight channels, an 8-bit data bus and a 12-bit count. With 12 bits, the count wraps after 4096 ticks, so the overflow flag can be set twice in one run: once for the normal-mode clear and once for the fast-clear. The upper count byte is then a partial byte, which exercises the zero-extending read path. Eight channels fill the whole data byte, so every flag bit position and every mask bit position is covered.

// File: rtl/tmrflg_pkg.sv
package tmrflg_pkg;
   localparam int BUS_AW = 3;
   localparam int MISC_W = 3;
   // misc flag / mask bit positions
   localparam int MB_OVF    = 0;
   localparam int MB_PAOVF  = 1;
   localparam int MB_PAEDGE = 2;
   // control bit positions
   localparam int CB_FAST = 0;
   localparam int CB_RUN  = 1;

   typedef enum logic [BUS_AW-1:0] {
      RA_CTRL    = 3'd0,
      RA_CHFLG   = 3'd1,
      RA_MISCFLG = 3'd2,
      RA_CHMSK   = 3'd3,
      RA_MISCMSK = 3'd4,
      RA_CNTHI   = 3'd5,
      RA_CNTLO   = 3'd6
   } reg_addr_e;
endpackage

// File: rtl/tmrflg_ctrl.sv
module tmrflg_ctrl (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_stb,
   input  logic [1:0] wdata,
   output logic       run,
   output logic       fast
);
   import tmrflg_pkg::*;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run  <= 1'b0;
         fast <= 1'b0;
      end else if (wr_stb) begin
         run  <= wdata[CB_RUN];
         fast <= wdata[CB_FAST];
      end
   end

   p_ctrl_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_stb |=> (run == $past(run)) && (fast == $past(fast)));
endmodule

// File: rtl/tmrflg_counter.sv
module tmrflg_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick,
   output logic [CNT_W-1:0] cnt,
   output logic             wrap
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   initial begin
      assert (CNT_W >= 2) else $error("tmrflg_counter: CNT_W too small");
   end

   logic step;
   assign step = run & tick;
   assign wrap = step & (cnt == CNT_MAX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (step) cnt <= cnt + 1'b1;
   end

   p_hold_when_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> $stable(cnt));
   p_wrap_to_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> (cnt == '0));
endmodule

// File: rtl/tmrflg_flagbank.sv
module tmrflg_flagbank #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_evt,
   input  logic         w1c_stb,
   input  logic [W-1:0] w1c_mask,
   input  logic         fast,
   input  logic [W-1:0] fast_clr,
   output logic [W-1:0] flg
);
   initial begin
      assert (W >= 1) else $error("tmrflg_flagbank: W must be positive");
   end

   for (genvar i = 0; i < W; i++) begin : g_bit
      logic clr_i;
      logic q;
      assign clr_i = fast ? fast_clr[i] : (w1c_stb & w1c_mask[i]);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          q <= 1'b0;
         else if (set_evt[i]) q <= 1'b1;   // set has priority
         else if (clr_i)      q <= 1'b0;
      end
      assign flg[i] = q;

      p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
         set_evt[i] |=> flg[i]);
   end

   p_w1c_blocked_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (fast && w1c_stb && fast_clr == '0 && set_evt == '0) |=> (flg == $past(flg)));
   p_fast_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (fast && set_evt == '0) |=> ((flg & $past(fast_clr)) == '0));
endmodule

// File: rtl/tmrflg_top.sv
module tmrflg_top #(
   parameter int NUM_CH = 8,
   parameter int DATA_W = 8,
   parameter int CNT_W  = 16
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        bus_sel,
   input  logic                        bus_wr,
   input  logic [tmrflg_pkg::BUS_AW-1:0] bus_addr,
   input  logic [DATA_W-1:0]           bus_wdata,
   output logic [DATA_W-1:0]           bus_rdata,
   input  logic                        tick,
   input  logic [NUM_CH-1:0]           ch_evt,
   input  logic                        pa_ovf_evt,
   input  logic                        pa_edge_evt,
   input  logic [NUM_CH-1:0]           cap_rd_stb,
   input  logic [NUM_CH-1:0]           cmp_wr_stb,
   input  logic                        pa_acc_stb,
   output logic [CNT_W-1:0]            count,
   output logic [NUM_CH-1:0]           irq_ch,
   output logic [tmrflg_pkg::MISC_W-1:0] irq_misc
);
   import tmrflg_pkg::*;

   localparam int HI_W = CNT_W - DATA_W;

   initial begin
      assert (NUM_CH >= 1 && NUM_CH <= DATA_W)
         else $error("tmrflg_top: NUM_CH must fit in one data word");
      assert (DATA_W >= MISC_W && DATA_W >= 2)
         else $error("tmrflg_top: DATA_W too narrow");
      assert (CNT_W > DATA_W && CNT_W <= 2 * DATA_W)
         else $error("tmrflg_top: CNT_W must span two bus words");
   end

   // ---------------- bus decode ----------------
   logic rd_acc, wr_acc;
   assign rd_acc = bus_sel & ~bus_wr;
   assign wr_acc = bus_sel &  bus_wr;

   logic ctrl_wr, chflg_wr, miscflg_wr, chmsk_wr, miscmsk_wr, cnt_acc;
   assign ctrl_wr    = wr_acc & (bus_addr == RA_CTRL);
   assign chflg_wr   = wr_acc & (bus_addr == RA_CHFLG);
   assign miscflg_wr = wr_acc & (bus_addr == RA_MISCFLG);
   assign chmsk_wr   = wr_acc & (bus_addr == RA_CHMSK);
   assign miscmsk_wr = wr_acc & (bus_addr == RA_MISCMSK);
   assign cnt_acc    = bus_sel & ((bus_addr == RA_CNTHI) | (bus_addr == RA_CNTLO));

   // ---------------- control and counter ----------------
   logic run, fast, wrap;

   tmrflg_ctrl u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_stb (ctrl_wr),
      .wdata  (bus_wdata[1:0]),
      .run    (run),
      .fast   (fast)
   );

   tmrflg_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run),
      .tick  (tick),
      .cnt   (count),
      .wrap  (wrap)
   );

   // ---------------- flag banks ----------------
   logic [NUM_CH-1:0] ch_flg;
   logic [MISC_W-1:0] misc_flg, misc_set, misc_fclr;

   tmrflg_flagbank #(.W(NUM_CH)) u_chflg (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_evt  (ch_evt),
      .w1c_stb  (chflg_wr),
      .w1c_mask (bus_wdata[NUM_CH-1:0]),
      .fast     (fast),
      .fast_clr (cap_rd_stb | cmp_wr_stb),
      .flg      (ch_flg)
   );

   always_comb begin
      misc_set              = '0;
      misc_set[MB_OVF]      = wrap;
      misc_set[MB_PAOVF]    = pa_ovf_evt;
      misc_set[MB_PAEDGE]   = pa_edge_evt;
      misc_fclr             = '0;
      misc_fclr[MB_OVF]     = cnt_acc;
      misc_fclr[MB_PAOVF]   = pa_acc_stb;
      misc_fclr[MB_PAEDGE]  = pa_acc_stb;
   end

   tmrflg_flagbank #(.W(MISC_W)) u_miscflg (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_evt  (misc_set),
      .w1c_stb  (miscflg_wr),
      .w1c_mask (bus_wdata[MISC_W-1:0]),
      .fast     (fast),
      .fast_clr (misc_fclr),
      .flg      (misc_flg)
   );

   // ---------------- interrupt masks ----------------
   logic [NUM_CH-1:0] ch_msk;
   logic [MISC_W-1:0] misc_msk;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ch_msk   <= '0;
         misc_msk <= '0;
      end else begin
         if (chmsk_wr)   ch_msk   <= bus_wdata[NUM_CH-1:0];
         if (miscmsk_wr) misc_msk <= bus_wdata[MISC_W-1:0];
      end
   end

   assign irq_ch   = ch_flg & ch_msk;
   assign irq_misc = misc_flg & misc_msk;

   // ---------------- count byte views ----------------
   logic [DATA_W-1:0] cnt_lo, cnt_hi;
   assign cnt_lo = count[DATA_W-1:0];
   if (HI_W == DATA_W) begin : g_hi_full
      assign cnt_hi = count[CNT_W-1:DATA_W];
   end else begin : g_hi_part
      assign cnt_hi = {{(DATA_W-HI_W){1'b0}}, count[CNT_W-1:DATA_W]};
   end

   // ---------------- read mux ----------------
   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         RA_CTRL: begin
            bus_rdata[CB_RUN]  = run;
            bus_rdata[CB_FAST] = fast;
         end
         RA_CHFLG:   bus_rdata[NUM_CH-1:0] = ch_flg;
         RA_MISCFLG: bus_rdata[MISC_W-1:0] = misc_flg;
         RA_CHMSK:   bus_rdata[NUM_CH-1:0] = ch_msk;
         RA_MISCMSK: bus_rdata[MISC_W-1:0] = misc_msk;
         RA_CNTHI:   bus_rdata = cnt_hi;
         RA_CNTLO:   bus_rdata = cnt_lo;
         default:    bus_rdata = '0;
      endcase
   end

   // ---------------- assertions ----------------
   p_ctrl_reserved_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == RA_CTRL) |-> (bus_rdata[DATA_W-1:2] == '0));
   p_pa_pair_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (fast && pa_acc_stb && !pa_ovf_evt && !pa_edge_evt)
         |=> (misc_flg[MB_PAOVF] == 1'b0 && misc_flg[MB_PAEDGE] == 1'b0));
   p_ovf_fastclr_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (fast && cnt_acc && !wrap) |=> !misc_flg[MB_OVF]);
   p_ovf_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> misc_flg[MB_OVF]);
   p_irq_masked_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(irq_misc) || ($countones(irq_misc) <= $countones(misc_msk)));
endmodule

// File: tb/tb_tmrflg_top.sv
module tb_tmrflg_top;
   localparam int NUM_CH = 8;
   localparam int DATA_W = 8;
   localparam int CNT_W  = 12;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bus_sel = 1'b0, bus_wr = 1'b0;
   logic [2:0] bus_addr = '0;
   logic [DATA_W-1:0] bus_wdata = '0;
   logic [DATA_W-1:0] bus_rdata;
   logic tick = 1'b0;
   logic [NUM_CH-1:0] ch_evt = '0, cap_rd_stb = '0, cmp_wr_stb = '0;
   logic pa_ovf_evt = 1'b0, pa_edge_evt = 1'b0, pa_acc_stb = 1'b0;
   logic [CNT_W-1:0] count;
   logic [NUM_CH-1:0] irq_ch;
   logic [2:0] irq_misc;

   int n_chk = 0, n_bad = 0;
   int exp_cnt = 0;
   bit done = 0;

   always #10 clk = ~clk;   // 50 MHz

   tmrflg_top #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .CNT_W(CNT_W)) dut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .tick(tick), .ch_evt(ch_evt), .pa_ovf_evt(pa_ovf_evt),
      .pa_edge_evt(pa_edge_evt), .cap_rd_stb(cap_rd_stb),
      .cmp_wr_stb(cmp_wr_stb), .pa_acc_stb(pa_acc_stb), .count(count),
      .irq_ch(irq_ch), .irq_misc(irq_misc)
   );

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   // peek without a bus access (bus_sel stays 0, so no side effect)
   task automatic peek(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic run_ticks(input int n);
      @(negedge clk);
      tick = 1'b1;
      repeat (n) @(negedge clk);
      tick = 1'b0;
      exp_cnt = (exp_cnt + n) % (1 << CNT_W);
   endtask

   task automatic t_reset();
      logic [7:0] d;
      peek(3'd0, d); check("R1 ctrl reset", d, 0);
      peek(3'd1, d); check("R11 chflg reset", d, 0);
      peek(3'd2, d); check("R11 miscflg reset", d, 0);
      check("R2 count reset", count, 0);
   endtask

   task automatic t_ctrl();
      logic [7:0] d;
      wr(3'd0, 8'hFC); rd(3'd0, d); check("R1 reserved bits ignored", d, 8'h00);
      wr(3'd0, 8'hFF); rd(3'd0, d); check("R1 ctrl readback", d, 8'h03);
      wr(3'd0, 8'h00); rd(3'd0, d); check("R1 ctrl cleared", d, 8'h00);
   endtask

   task automatic t_count();
      logic [7:0] lo, hi;
      run_ticks(7); check("R2 no count while stopped", count, 0);
      wr(3'd3, 8'h5A); rd(3'd3, lo); check("R2 regs writable while stopped", lo, 8'h5A);
      wr(3'd3, 8'h00);
      exp_cnt = 0;
      wr(3'd0, 8'h02);
      run_ticks(300);
      wr(3'd0, 8'h00);
      rd(3'd6, lo); rd(3'd5, hi);
      check("R2 count value", {hi, lo}, exp_cnt);
      run_ticks(5); exp_cnt = 300;
      check("R2 hold when disabled", count, 300);
   endtask

   task automatic t_wrap();
      logic [7:0] d;
      wr(3'd0, 8'h02);
      run_ticks((1 << CNT_W) - 1 - exp_cnt);
      peek(3'd2, d); check("R3 no overflow before wrap", d[0], 0);
      check("R3 count at max", count, (1 << CNT_W) - 1);
      run_ticks(1);
      wr(3'd0, 8'h00);
      check("R3 count wrapped", count, 0);
      peek(3'd2, d); check("R3 overflow set", d, 8'h01);
      rd(3'd6, d); peek(3'd2, d); check("R7 normal-mode count read keeps flag", d, 8'h01);
      wr(3'd2, 8'h00); peek(3'd2, d); check("R4 write 0 no effect", d, 8'h01);
      wr(3'd2, 8'h01); peek(3'd2, d); check("R4 write 1 clears overflow", d, 8'h00);
   endtask

   task automatic t_w1c();
      logic [7:0] d;
      @(negedge clk); ch_evt = 8'hA5; @(negedge clk); ch_evt = '0;
      peek(3'd1, d); check("R11 channel events set flags", d, 8'hA5);
      cap_rd_stb = 8'h01; @(negedge clk); cap_rd_stb = '0;
      peek(3'd1, d); check("R6 normal-mode strobe clears nothing", d, 8'hA5);
      wr(3'd1, 8'h05); peek(3'd1, d); check("R4 channel w1c", d, 8'hA0);
      wr(3'd1, 8'h00); peek(3'd1, d); check("R4 channel write 0", d, 8'hA0);
   endtask

   task automatic t_irq();
      logic [7:0] d;
      wr(3'd3, 8'h2F);
      @(negedge clk); #1 check("R10 channel irq masked", irq_ch, 8'h20);
      @(negedge clk); pa_ovf_evt = 1'b1; pa_edge_evt = 1'b1;
      @(negedge clk); pa_ovf_evt = 1'b0; pa_edge_evt = 1'b0;
      peek(3'd2, d); check("R11 pa flags set", d, 8'h06);
      wr(3'd4, 8'h04);
      @(negedge clk); #1 check("R10 misc irq masked", irq_misc, 3'b100);
      @(negedge clk); pa_acc_stb = 1'b1; @(negedge clk); pa_acc_stb = 1'b0;
      peek(3'd2, d); check("R8 normal-mode pa access keeps flags", d, 8'h06);
   endtask

   task automatic t_fast();
      logic [7:0] d;
      wr(3'd0, 8'h01);
      wr(3'd1, 8'hFF); peek(3'd1, d); check("R5 fast mode blocks chflg w1c", d, 8'hA0);
      wr(3'd2, 8'hFF); peek(3'd2, d); check("R5 fast mode blocks miscflg w1c", d, 8'h06);
      @(negedge clk); cap_rd_stb = 8'h20; @(negedge clk); cap_rd_stb = '0;
      peek(3'd1, d); check("R6 capture read clears its channel", d, 8'h80);
      @(negedge clk); cmp_wr_stb = 8'h80; @(negedge clk); cmp_wr_stb = '0;
      peek(3'd1, d); check("R6 compare write clears its channel", d, 8'h00);
      @(negedge clk); pa_acc_stb = 1'b1; @(negedge clk); pa_acc_stb = 1'b0;
      peek(3'd2, d); check("R8 pa access clears both", d, 8'h00);
      // set wins
      @(negedge clk); ch_evt = 8'h08; cap_rd_stb = 8'h08;
      @(negedge clk); ch_evt = '0; cap_rd_stb = '0;
      peek(3'd1, d); check("R9 set beats fast clear", d, 8'h08);
      @(negedge clk); pa_ovf_evt = 1'b1; pa_acc_stb = 1'b1;
      @(negedge clk); pa_ovf_evt = 1'b0; pa_acc_stb = 1'b0;
      peek(3'd2, d); check("R9 set beats pa clear", d, 8'h02);
      // overflow fast clear through count access
      wr(3'd0, 8'h03);
      run_ticks((1 << CNT_W) - exp_cnt);
      wr(3'd0, 8'h01);
      peek(3'd2, d); check("R3 second overflow", d, 8'h03);
      rd(3'd6, d); peek(3'd2, d); check("R7 count read clears overflow", d, 8'h02);
   endtask

   task automatic t_setwins_normal();
      logic [7:0] d;
      wr(3'd0, 8'h00);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 3'd1; bus_wdata = 8'h18; ch_evt = 8'h10;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0; ch_evt = '0;
      peek(3'd1, d); check("R9 set beats w1c", d, 8'h10);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_ctrl();
      t_count();
      t_wrap();
      t_w1c();
      t_irq();
      t_fast();
      t_setwins_normal();
      if (!done) begin
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_chk++; n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule